// File: doc/BRIEF.md
# Push-Button Melody Step Sequencer

This block plays a fixed sixteen-step tune once each time a button is pressed. A four-bit step index moves by one position every time a slow step tick fires. The tick comes from a divider on the system clock; at about five steps per second each note sounds for roughly 200 ms. Each step index is decoded into a one-hot choice among five notes, C to G. That choice routes one of five pitch square waves, made outside the block, onto a single audio line. Three steps carry no note and leave the line silent.

The press is synchronised and edge-detected. A press while idle starts one pass, running upward from step 0 or downward from step 15 according to a direction input sampled at the press. After sixteen steps the block goes idle and mutes the line. A press during a pass is ignored, and so is a change of the direction input during a pass. Step index and busy flag are brought out for observation.

Top module: `mel_seq_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy_o` is 0, `step_o` is 0, `note_sel_o` is 00000 and `audio_o` is 0.
- R2: A rising level on `btn_i` that is first seen at a clock edge sets `busy_o` on the third clock edge after it. Holding the button high starts no further pass.
- R3: At the start of a pass `step_o` is 0 when `dir_i` is 0 (count up), or 15 when `dir_i` is 1 (count down). `dir_i` is sampled only at the start.
- R4: During a pass each step index is held for exactly `STEP_CYCLES` clock cycles. It then moves by one, upward or downward as chosen at the start.
- R5: A pass visits all 16 indices once. After the last index (15 up, 0 down) has been held, `busy_o` falls and `step_o` returns to 0.
- R6: `note_sel_o` is one-hot while a note sounds. Bit 4 is C, bit 3 is D, bit 2 is E, bit 1 is F and bit 0 is G. The index-to-note map is: 8 to C; 5, 6 and 9 to D; 1, 2 and 10 to E; 4 and 11 to F; 0, 12, 13 and 14 to G.
- R7: Steps 3, 7 and 15 are rests. `note_sel_o` is 00000 on them and `audio_o` is 0.
- R8: `audio_o` equals the bit of `tone_i` that the one-hot select names, using the same bit order as `note_sel_o`. It follows that input with no clock delay.
- R9: A press of `btn_i` during a pass, or a change of `dir_i` during a pass, does not alter the step sequence or its timing.
- R10: While idle, `note_sel_o` is 00000 and `audio_o` is 0 whatever `tone_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| btn_i | input | 1 | Raw start push button, asynchronous |
| dir_i | input | 1 | Direction, 0 counts up, 1 counts down; sampled at start |
| tone_i | input | 5 | Pitch square waves, bit 4 C down to bit 0 G |
| audio_o | output | 1 | Selected pitch, or low when silent |
| note_sel_o | output | 5 | One-hot note select, bit 4 C down to bit 0 G |
| step_o | output | 4 | Current step index |
| busy_o | output | 1 | High while a pass is playing |

## Verification
Four properties are checked on every clock cycle. The note select is never more than one-hot. Idle and rest steps keep the audio low. Every index change during a pass is a single step in the latched direction and comes only after a full hold of `STEP_CYCLES` cycles. A pass begins at the correct end. The index-to-note map, the audio routing under changing tone patterns, the exact three-edge start latency, the length of the pass and its return to idle are shown only by the bench. The same holds for ignored mid-pass presses and direction changes, and for reset in the middle of a pass. The bench sweeps every step of an upward and a downward pass with a short divider.

// File: rtl/mel_pkg.sv
package mel_pkg;
  localparam int unsigned NOTES  = 5;
  localparam int unsigned STEP_W = 4;
  localparam int unsigned STEPS  = 1 << STEP_W;

  typedef logic [NOTES-1:0]  note_t;
  typedef logic [STEP_W-1:0] step_t;

  // one-hot bit positions; bit 4 is C, bit 0 is G
  localparam int unsigned IDX_C = 4;
  localparam int unsigned IDX_D = 3;
  localparam int unsigned IDX_E = 2;
  localparam int unsigned IDX_F = 1;
  localparam int unsigned IDX_G = 0;

  function automatic note_t note_of_step(input step_t s);
    note_t n;
    n = '0;
    case (s)
      4'd8:                       n[IDX_C] = 1'b1;
      4'd5, 4'd6, 4'd9:           n[IDX_D] = 1'b1;
      4'd1, 4'd2, 4'd10:          n[IDX_E] = 1'b1;
      4'd4, 4'd11:                n[IDX_F] = 1'b1;
      4'd0, 4'd12, 4'd13, 4'd14:  n[IDX_G] = 1'b1;
      default:                    n = '0; // rests: 3, 7, 15
    endcase
    return n;
  endfunction
endpackage

// File: rtl/mel_btn_sync.sv
module mel_btn_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= btn_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/mel_tick_div.sv
module mel_tick_div #(
  parameter int unsigned STEP_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned DIV_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(STEP_CYCLES - 1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign cnt_en  = clr_i | en_i;
  assign tick_o  = en_i & ~clr_i & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || at_last) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mel_step_ctr.sv
module mel_step_ctr
  import mel_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rise_i,
  input  logic  dir_i,
  input  logic  tick_i,
  output logic  start_o,
  output step_t step_o,
  output logic  busy_o,
  output logic  dir_q_o
);
  step_t step_q, step_d;
  logic  busy_q, busy_d;
  logic  dir_q, dir_d;
  logic  at_end;
  logic  upd_en;

  assign start_o = rise_i & ~busy_q;
  assign at_end  = dir_q ? (step_q == '0) : (step_q == '1);
  assign upd_en  = start_o | (busy_q & tick_i);

  always_comb begin
    step_d = step_q;
    busy_d = busy_q;
    dir_d  = dir_q;
    if (start_o) begin
      busy_d = 1'b1;
      dir_d  = dir_i;
      step_d = dir_i ? '1 : '0;
    end else if (busy_q && tick_i) begin
      if (at_end) begin
        busy_d = 1'b0;
        step_d = '0;
      end else if (dir_q) begin
        step_d = step_q - 1'b1;
      end else begin
        step_d = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
    end else if (upd_en) begin
      step_q <= step_d;
      busy_q <= busy_d;
      dir_q  <= dir_d;
    end
  end

  assign step_o  = step_q;
  assign busy_o  = busy_q;
  assign dir_q_o = dir_q;
endmodule

// File: rtl/mel_note_dec.sv
module mel_note_dec
  import mel_pkg::*;
(
  input  step_t step_i,
  input  logic  en_i,
  output note_t sel_o
);
  note_t raw;
  assign raw   = note_of_step(step_i);
  assign sel_o = en_i ? raw : '0;
endmodule

// File: rtl/mel_tone_sel.sv
module mel_tone_sel
  import mel_pkg::*;
(
  input  note_t sel_i,
  input  note_t tone_i,
  output logic  audio_o
);
  note_t gated;
  for (genvar n = 0; n < NOTES; n++) begin : g_gate
    assign gated[n] = sel_i[n] & tone_i[n];
  end
  assign audio_o = |gated;
endmodule

// File: rtl/mel_seq_top.sv
module mel_seq_top
  import mel_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 10_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_i,
  input  logic       dir_i,
  input  logic [4:0] tone_i,
  output logic       audio_o,
  output logic [4:0] note_sel_o,
  output logic [3:0] step_o,
  output logic       busy_o
);
  logic  rise;
  logic  tick;
  logic  start;
  logic  busy;
  logic  dir_q;
  step_t step;
  note_t sel;

  mel_btn_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .btn_i  (btn_i),
    .rise_o (rise)
  );

  mel_tick_div #(.STEP_CYCLES(STEP_CYCLES)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (busy),
    .clr_i  (start),
    .tick_o (tick)
  );

  mel_step_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_i  (rise),
    .dir_i   (dir_i),
    .tick_i  (tick),
    .start_o (start),
    .step_o  (step),
    .busy_o  (busy),
    .dir_q_o (dir_q)
  );

  mel_note_dec u_dec (
    .step_i (step),
    .en_i   (busy),
    .sel_o  (sel)
  );

  mel_tone_sel u_sel (
    .sel_i   (sel),
    .tone_i  (tone_i),
    .audio_o (audio_o)
  );

  assign note_sel_o = sel;
  assign step_o     = step;
  assign busy_o     = busy;
endmodule

// File: rtl/mel_seq_chk.sv
module mel_seq_chk #(
  parameter int unsigned STEP_CYCLES = 10_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       dir_q,
  input logic [3:0] step,
  input logic [4:0] sel,
  input logic       audio
);
  logic [3:0]  prev_step;
  logic        prev_busy;
  logic [31:0] hold;
  logic        moved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_step <= '0;
      prev_busy <= 1'b0;
      hold      <= '0;
    end else begin
      prev_step <= step;
      prev_busy <= busy;
      if (!busy)                          hold <= '0;
      else if (!prev_busy || moved)       hold <= 32'd1;
      else if (hold != 32'hFFFF_FFFF)     hold <= hold + 32'd1;
    end
  end

  assign moved = busy && prev_busy && (step != prev_step);

  AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R6
  AST_IDLE_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sel == 5'b0 && !audio)); // R10
  AST_REST_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 5'b0) |-> !audio); // R7
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    moved |-> (step == (dir_q ? prev_step - 4'd1 : prev_step + 4'd1))); // R4
  AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    moved |-> (hold == STEP_CYCLES)); // R4
  AST_START_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prev_busy) |-> (step == (dir_q ? 4'd15 : 4'd0))); // R3
endmodule

bind mel_seq_top mel_seq_chk #(.STEP_CYCLES(STEP_CYCLES)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .dir_q (dir_q),
  .step  (step),
  .sel   (sel),
  .audio (audio_o)
);

// File: tb/mel_seq_top_tb_top.sv
module mel_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SC         = 4;
  localparam int WATCHDOG   = 50_000;

  logic       clk;
  logic       rst_n;
  logic       btn_i;
  logic       dir_i;
  logic [4:0] tone_i;
  logic       audio_o;
  logic [4:0] note_sel_o;
  logic [3:0] step_o;
  logic       busy_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic [7:0] lfsr = 8'hA5;

  mel_seq_top #(.STEP_CYCLES(SC)) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .dir_i(dir_i),
    .tone_i(tone_i), .audio_o(audio_o), .note_sel_o(note_sel_o),
    .step_o(step_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // expected one-hot from the requirement map (bit4 C .. bit0 G)
  function automatic logic [4:0] exp_sel(input int s);
    case (s)
      8:              return 5'b10000;
      5, 6, 9:        return 5'b01000;
      1, 2, 10:       return 5'b00100;
      4, 11:          return 5'b00010;
      0, 12, 13, 14:  return 5'b00001;
      default:        return 5'b00000;
    endcase
  endfunction

  task automatic new_tones();
    lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tone_i = lfsr[4:0];
  endtask

  task automatic check_idle(input string tag);
    check(busy_o == 1'b0, {tag, " busy"}, busy_o, 0);
    check(step_o == 4'd0, {tag, " step"}, step_o, 0);
    check(note_sel_o == 5'd0, {tag, " sel"}, note_sel_o, 0);
    check(audio_o == 1'b0, {tag, " audio"}, audio_o, 0);
  endtask

  // one full pass; optionally disturb with a press and direction flip (R9)
  task automatic run_pass(input bit down, input bit disturb);
    int lat;
    int s;
    @(negedge clk);
    dir_i = down;
    btn_i = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!busy_o && lat < 10);
    check(lat == 3, "R2 start latency", lat, 3);
    for (int i = 0; i < 16*SC; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 2) btn_i = 1'b0;
      if (disturb && i == 5*SC) btn_i = 1'b1;
      if (disturb && i == 5*SC + 4) btn_i = 1'b0;
      if (disturb && i == 7*SC + 1) dir_i = ~down;
      s = down ? 15 - i/SC : i/SC;
      check(busy_o == 1'b1, "R5 busy in pass", busy_o, 1);
      if (i == 0) check(step_o == s, "R3 start index", step_o, s);
      else if (disturb) check(step_o == s, "R9 step undisturbed", step_o, s);
      else check(step_o == s, "R4 step timing", step_o, s);
      check(note_sel_o == exp_sel(s), "R6 note map", note_sel_o, exp_sel(s));
      if (exp_sel(s) == 5'd0)
        check(audio_o == 1'b0, "R7 rest silent", audio_o, 0);
      new_tones();
      #1;
      check(audio_o == |(exp_sel(s) & tone_i), "R8 audio route",
            audio_o, |(exp_sel(s) & tone_i));
    end
    @(negedge clk);
    check_idle("R5 end of pass");
    dir_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      new_tones();
      #1;
      check(audio_o == 1'b0 && note_sel_o == 5'd0, "R10 idle mute",
            audio_o, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    btn_i  = 1'b0;
    dir_i  = 1'b0;
    tone_i = 5'h1F;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 after reset");

    run_pass(1'b0, 1'b0);
    run_pass(1'b1, 1'b0);
    run_pass(1'b0, 1'b1);
    run_pass(1'b1, 1'b1);

    // held button must not restart after a pass ends (R2)
    @(negedge clk);
    btn_i = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_o == 1'b1, "R2 press starts", busy_o, 1);
    repeat (16*SC + 5) @(negedge clk);
    check(busy_o == 1'b0, "R2 hold no restart", busy_o, 0);
    btn_i = 1'b0;

    // reset in mid pass (R1)
    repeat (3) @(negedge clk);
    btn_i = 1'b1;
    repeat (3*SC) @(negedge clk);
    btn_i = 1'b0;
    rst_n = 1'b0;
    #1;
    check_idle("R1 mid-pass reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 after mid-pass reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule